// File: doc/BRIEF.md
# Counter-Rotating Dual Ring Transport

This block moves data packets between a set of ring stops over two rings that circulate in opposite directions. One ring carries traffic clockwise (stop i to stop i+1), the other counter-clockwise (stop i to stop i-1). Each stop has one local injection port and two ejection ports, one per ring. A packet carries a destination stop number, a client tag and a payload as wide as the memory bus. The injecting stop puts it on the ring with the shorter path, so no packet passes more than half of the ring. When both paths are the same length, it takes the clockwise ring.

In the default build, stops 0 to 3 are the primary stops. Each one sits next to a pair of DRAM channels, so read data enters the ring at the stop that owns the channel. Stop 4 is a small auxiliary stop for host-bus and video-input traffic, and it injects only a narrow payload. A packet leaves the ring at the stop nearest the requesting client. Every hop passes through a register, so a packet spends one cycle per hop. Traffic already circulating always wins over new injection. A stop whose chosen ring slot is occupied holds its local source off with a low ready.

Top module: `ring_interconnect`

## Requirements
- R1: After reset, every ejection valid is low and every injection ready is high.
- R2: With `d = (dest - src) mod N_STOPS`, a packet uses the clockwise ring when `2*d <= N_STOPS` and the counter-clockwise ring otherwise. It appears on the destination's `ej_cw_*` or `ej_ccw_*` port to match the ring it used.
- R3: A packet accepted at a clock edge has its ejection valid high in the cycle after the h-th edge, counting the accepting edge as the first. Here h is `d` for the clockwise ring and `N_STOPS - d` for the counter-clockwise ring. No packet is ever carried more than `N_STOPS/2` hops.
- R4: When `d` is exactly half of an even stop count, the clockwise ring is used.
- R5: If a packet not addressed to a stop arrives on the ring that stop's injection would use, `inj_ready_o` at that stop is low and no injection takes place. The passing packet continues unchanged. On an idle ring, ready is high.
- R6: A slot emptied by a packet ejecting at a stop can take that stop's injection in the same cycle.
- R7: A packet is ejected only at its destination, for exactly one cycle, with its tag and payload intact.
- R8: An injection whose destination equals the injecting stop, or is not below `N_STOPS`, is accepted with ready high and then discarded. It is never ejected anywhere.
- R9: The auxiliary stop (number `N_STOPS-1`) keeps only the low `AUX_W` payload bits and clears the rest. All other stops carry the full payload.
- R10: Ready at a stop depends only on the ring its current destination selects. A busy opposite ring does not block injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inj_valid_i | input | N_STOPS | Injection request, one bit per stop |
| inj_dest_i | input | N_STOPS*ID_W | Destination stop number for each stop's injection |
| inj_tag_i | input | N_STOPS*TAG_W | Client tag for each stop's injection |
| inj_data_i | input | N_STOPS*DATA_W | Payload for each stop's injection |
| inj_ready_o | output | N_STOPS | Injection accepted when both valid and ready are high |
| ej_cw_valid_o | output | N_STOPS | Packet ejected from the clockwise ring at this stop |
| ej_cw_tag_o | output | N_STOPS*TAG_W | Tag of the clockwise ejection |
| ej_cw_data_o | output | N_STOPS*DATA_W | Payload of the clockwise ejection |
| ej_ccw_valid_o | output | N_STOPS | Packet ejected from the counter-clockwise ring at this stop |
| ej_ccw_tag_o | output | N_STOPS*TAG_W | Tag of the counter-clockwise ejection |
| ej_ccw_data_o | output | N_STOPS*DATA_W | Payload of the counter-clockwise ejection |

## Verification
Ready is a combinational function of the destination being presented and of the slot arriving at the stop. The bench therefore samples it one time unit after driving, still before the accepting edge. An ejection is due exactly h edges after acceptance, and each route check samples the destination's two valid bits on every falling edge from the first to the (h+1)-th. This confirms the valid is low before cycle h, high in cycle h and low again after it, with the expected ring chosen. Backpressure, slot reuse and discard cases are checked on the same edge-counted schedule. The tie rule is checked on a second instance built with four stops.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;

  // hops from 'from' to 'to' moving in the clockwise direction
  function automatic int cw_hops(input int from, input int to, input int n);
    return (to >= from) ? (to - from) : (to + n - from);
  endfunction

endpackage

// File: rtl/ring_dir_sel.sv
module ring_dir_sel
  import ring_pkg::*;
#(
  parameter int N_STOPS = 5,
  parameter int ID_W    = 3,
  parameter int MY_ID   = 0
) (
  input  logic [ID_W-1:0] dest_i,
  output ring_dir_e       dir_o,
  output logic            dest_ok_o
);

  int d;

  always_comb begin
    d         = cw_hops(MY_ID, int'(dest_i), N_STOPS);
    dest_ok_o = (int'(dest_i) < N_STOPS) && (int'(dest_i) != MY_ID);
    // exact half goes clockwise
    dir_o     = (2 * d <= N_STOPS) ? DIR_CW : DIR_CCW;
  end

endmodule

// File: rtl/ring_slot.sv
module ring_slot #(
  parameter int ID_W   = 3,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 256,
  parameter int MY_ID  = 0,
  localparam int PKT_W = 1 + ID_W + TAG_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PKT_W-1:0]  in_pkt_i,
  input  logic              ins_i,
  input  logic [PKT_W-1:0]  ins_pkt_i,
  output logic [PKT_W-1:0]  out_pkt_o,
  output logic              free_o,
  output logic              ej_valid_o,
  output logic [TAG_W-1:0]  ej_tag_o,
  output logic [DATA_W-1:0] ej_data_o
);

  logic            in_v;
  logic [ID_W-1:0] in_dest;
  logic            hit;

  assign in_v       = in_pkt_i[PKT_W-1];
  assign in_dest    = in_pkt_i[DATA_W+TAG_W +: ID_W];
  assign hit        = in_v && (int'(in_dest) == MY_ID);
  assign free_o     = !in_v || hit;
  assign ej_valid_o = hit;
  assign ej_tag_o   = in_pkt_i[DATA_W +: TAG_W];
  assign ej_data_o  = in_pkt_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               out_pkt_o <= '0;
    else if (ins_i)            out_pkt_o <= ins_pkt_i;
    else if (in_v && !hit)     out_pkt_o <= in_pkt_i;
    else                       out_pkt_o <= '0;
  end

  p_pass_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_v && !hit) |=> (out_pkt_o == $past(in_pkt_i)));

  p_no_overwrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> free_o);

  p_inject_hop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> (out_pkt_o == $past(ins_pkt_i)));

endmodule

// File: rtl/ring_stop.sv
module ring_stop
  import ring_pkg::*;
#(
  parameter int N_STOPS = 5,
  parameter int ID_W    = 3,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 256,
  parameter int AUX_W   = 16,
  parameter int MY_ID   = 0,
  localparam int PKT_W  = 1 + ID_W + TAG_W + DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0][PKT_W-1:0]      in_pkt_i,   // [0] clockwise, [1] counter-clockwise
  output logic [1:0][PKT_W-1:0]      out_pkt_o,
  input  logic                       inj_valid_i,
  input  logic [ID_W-1:0]            inj_dest_i,
  input  logic [TAG_W-1:0]           inj_tag_i,
  input  logic [DATA_W-1:0]          inj_data_i,
  output logic                       inj_ready_o,
  output logic [1:0]                 ej_valid_o,
  output logic [1:0][TAG_W-1:0]      ej_tag_o,
  output logic [1:0][DATA_W-1:0]     ej_data_o
);

  localparam bit IS_AUX = (MY_ID == N_STOPS - 1);
  localparam logic [DATA_W-1:0] AUX_MASK = (DATA_W'(1) << AUX_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] PAY_MASK = IS_AUX ? AUX_MASK : '1;

  ring_dir_e        sel_dir;
  logic             dest_ok;
  logic [1:0]       free;
  logic [1:0]       ins;
  logic             fire;
  logic [PKT_W-1:0] ins_pkt;

  ring_dir_sel #(
    .N_STOPS (N_STOPS),
    .ID_W    (ID_W),
    .MY_ID   (MY_ID)
  ) u_dir (
    .dest_i    (inj_dest_i),
    .dir_o     (sel_dir),
    .dest_ok_o (dest_ok)
  );

  assign inj_ready_o = dest_ok ? ((sel_dir == DIR_CW) ? free[0] : free[1]) : 1'b1;
  assign fire        = inj_valid_i && inj_ready_o && dest_ok;
  assign ins_pkt     = {1'b1, inj_dest_i, inj_tag_i, inj_data_i & PAY_MASK};

  for (genvar r = 0; r < 2; r++) begin : g_ring
    assign ins[r] = fire && (sel_dir == ((r == 0) ? DIR_CW : DIR_CCW));

    ring_slot #(
      .ID_W   (ID_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W),
      .MY_ID  (MY_ID)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .in_pkt_i   (in_pkt_i[r]),
      .ins_i      (ins[r]),
      .ins_pkt_i  (ins_pkt),
      .out_pkt_o  (out_pkt_o[r]),
      .free_o     (free[r]),
      .ej_valid_o (ej_valid_o[r]),
      .ej_tag_o   (ej_tag_o[r]),
      .ej_data_o  (ej_data_o[r])
    );

    if (IS_AUX && (AUX_W < DATA_W)) begin : g_aux_chk
      p_aux_narrow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins[r] |=> (out_pkt_o[r][AUX_W +: (DATA_W-AUX_W)] == '0));
    end
  end

  p_single_ring_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ins) <= 1);

endmodule

// File: rtl/ring_interconnect.sv
module ring_interconnect
  import ring_pkg::*;
#(
  parameter int N_STOPS = 5,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 256,
  parameter int AUX_W   = 16,
  localparam int ID_W   = (N_STOPS > 1) ? $clog2(N_STOPS) : 1,
  localparam int PKT_W  = 1 + ID_W + TAG_W + DATA_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_STOPS-1:0]          inj_valid_i,
  input  logic [N_STOPS*ID_W-1:0]     inj_dest_i,
  input  logic [N_STOPS*TAG_W-1:0]    inj_tag_i,
  input  logic [N_STOPS*DATA_W-1:0]   inj_data_i,
  output logic [N_STOPS-1:0]          inj_ready_o,
  output logic [N_STOPS-1:0]          ej_cw_valid_o,
  output logic [N_STOPS*TAG_W-1:0]    ej_cw_tag_o,
  output logic [N_STOPS*DATA_W-1:0]   ej_cw_data_o,
  output logic [N_STOPS-1:0]          ej_ccw_valid_o,
  output logic [N_STOPS*TAG_W-1:0]    ej_ccw_tag_o,
  output logic [N_STOPS*DATA_W-1:0]   ej_ccw_data_o
);

  // registered hop leaving each stop, [0] clockwise, [1] counter-clockwise
  logic [1:0][PKT_W-1:0] hop_q [N_STOPS];

  for (genvar i = 0; i < N_STOPS; i++) begin : g_stop
    localparam int PREV = (i + N_STOPS - 1) % N_STOPS;
    localparam int NEXT = (i + 1) % N_STOPS;

    logic [1:0][PKT_W-1:0]  in_pkt;
    logic [1:0]             ej_v;
    logic [1:0][TAG_W-1:0]  ej_t;
    logic [1:0][DATA_W-1:0] ej_d;

    assign in_pkt[0] = hop_q[PREV][0];
    assign in_pkt[1] = hop_q[NEXT][1];

    ring_stop #(
      .N_STOPS (N_STOPS),
      .ID_W    (ID_W),
      .TAG_W   (TAG_W),
      .DATA_W  (DATA_W),
      .AUX_W   (AUX_W),
      .MY_ID   (i)
    ) u_stop (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_pkt_i    (in_pkt),
      .out_pkt_o   (hop_q[i]),
      .inj_valid_i (inj_valid_i[i]),
      .inj_dest_i  (inj_dest_i[i*ID_W +: ID_W]),
      .inj_tag_i   (inj_tag_i[i*TAG_W +: TAG_W]),
      .inj_data_i  (inj_data_i[i*DATA_W +: DATA_W]),
      .inj_ready_o (inj_ready_o[i]),
      .ej_valid_o  (ej_v),
      .ej_tag_o    (ej_t),
      .ej_data_o   (ej_d)
    );

    assign ej_cw_valid_o[i]                  = ej_v[0];
    assign ej_ccw_valid_o[i]                 = ej_v[1];
    assign ej_cw_tag_o[i*TAG_W +: TAG_W]     = ej_t[0];
    assign ej_ccw_tag_o[i*TAG_W +: TAG_W]    = ej_t[1];
    assign ej_cw_data_o[i*DATA_W +: DATA_W]  = ej_d[0];
    assign ej_ccw_data_o[i*DATA_W +: DATA_W] = ej_d[1];

    // remaining distance of every packet in flight stays within half the ring
    int cw_left, ccw_left;
    always_comb begin
      cw_left  = cw_hops(i, int'(hop_q[i][0][DATA_W+TAG_W +: ID_W]), N_STOPS);
      ccw_left = cw_hops(int'(hop_q[i][1][DATA_W+TAG_W +: ID_W]), i, N_STOPS);
    end

    p_cw_half_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hop_q[i][0][PKT_W-1] |-> (cw_left >= 1 && 2 * cw_left <= N_STOPS));

    p_ccw_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hop_q[i][1][PKT_W-1] |-> (ccw_left >= 1 && 2 * ccw_left < N_STOPS));
  end

endmodule

// File: tb/ring_interconnect_bench.sv
`timescale 1ns/1ps
module ring_interconnect_bench;

  localparam int N  = 5;
  localparam int IW = 3;
  localparam int TW = 4;
  localparam int DW = 256;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]    inj_valid = '0;
  logic [N*IW-1:0] inj_dest  = '0;
  logic [N*TW-1:0] inj_tag   = '0;
  logic [N*DW-1:0] inj_data  = '0;
  logic [N-1:0]    inj_ready;
  logic [N-1:0]    cw_v, ccw_v;
  logic [N*TW-1:0] cw_t, ccw_t;
  logic [N*DW-1:0] cw_d, ccw_d;

  ring_interconnect #(.N_STOPS(N), .TAG_W(TW), .DATA_W(DW), .AUX_W(AW)) u_ring_interconnect (
    .clk_i(clk), .rst_ni(rst_n),
    .inj_valid_i(inj_valid), .inj_dest_i(inj_dest), .inj_tag_i(inj_tag), .inj_data_i(inj_data),
    .inj_ready_o(inj_ready),
    .ej_cw_valid_o(cw_v), .ej_cw_tag_o(cw_t), .ej_cw_data_o(cw_d),
    .ej_ccw_valid_o(ccw_v), .ej_ccw_tag_o(ccw_t), .ej_ccw_data_o(ccw_d)
  );

  // four-stop instance for the tie rule
  logic [3:0]  r4_valid = '0;
  logic [7:0]  r4_dest  = '0;
  logic [15:0] r4_tag   = '0;
  logic [127:0] r4_data = '0;
  logic [3:0]  r4_ready, r4_cw_v, r4_ccw_v;
  logic [15:0] r4_cw_t, r4_ccw_t;
  logic [127:0] r4_cw_d, r4_ccw_d;

  ring_interconnect #(.N_STOPS(4), .TAG_W(4), .DATA_W(32), .AUX_W(8)) u_ring4 (
    .clk_i(clk), .rst_ni(rst_n),
    .inj_valid_i(r4_valid), .inj_dest_i(r4_dest), .inj_tag_i(r4_tag), .inj_data_i(r4_data),
    .inj_ready_o(r4_ready),
    .ej_cw_valid_o(r4_cw_v), .ej_cw_tag_o(r4_cw_t), .ej_cw_data_o(r4_cw_d),
    .ej_ccw_valid_o(r4_ccw_v), .ej_ccw_tag_o(r4_ccw_t), .ej_ccw_data_o(r4_ccw_d)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int s, input logic v, input logic [IW-1:0] d,
                       input logic [TW-1:0] t, input logic [DW-1:0] x);
    inj_valid[s]         = v;
    inj_dest[s*IW +: IW] = d;
    inj_tag[s*TW +: TW]  = t;
    inj_data[s*DW +: DW] = x;
  endtask

  function automatic logic [DW-1:0] pat(input logic [TW-1:0] t);
    return {8{16'hD00D, 12'h0, t}};
  endfunction

  localparam logic [DW-1:0] AUX_KEEP = {{(DW-AW){1'b0}}, {AW{1'b1}}};

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk("R1 eject valids after reset", DW'({cw_v, ccw_v}), '0);
    chk("R1 ready after reset", DW'(inj_ready), DW'({N{1'b1}}));
  endtask

  // R2 R3 R7 R9: one packet, edge-counted arrival
  task automatic t_route(input int src, input int dst);
    int d, h;
    logic dir_ccw;
    logic [TW-1:0] tag;
    logic [DW-1:0] exp_data;
    d = (dst + N - src) % N;
    dir_ccw = !(2 * d <= N);
    h = dir_ccw ? N - d : d;
    tag = TW'((src * 5 + dst) % 16);
    exp_data = (src == N - 1) ? (pat(tag) & AUX_KEEP) : pat(tag);
    @(negedge clk);
    drive(src, 1'b1, IW'(dst), tag, pat(tag));
    #1 chk("R5 ready on idle ring", DW'(inj_ready[src]), DW'(1));
    @(negedge clk);
    drive(src, 1'b0, '0, '0, '0);
    for (int k = 1; k <= h + 1; k++) begin
      if (k > 1) @(negedge clk);
      chk($sformatf("R3 R2 valids %0d->%0d cycle %0d", src, dst, k),
          DW'({cw_v[dst], ccw_v[dst]}),
          DW'((k == h) ? (dir_ccw ? 2'b01 : 2'b10) : 2'b00));
      chk("R7 single ejection", DW'($countones({cw_v, ccw_v})), DW'((k == h) ? 1 : 0));
      if (k == h) begin
        chk("R7 tag", DW'(dir_ccw ? ccw_t[dst*TW +: TW] : cw_t[dst*TW +: TW]), DW'(tag));
        chk("R9 R7 payload", dir_ccw ? ccw_d[dst*DW +: DW] : cw_d[dst*DW +: DW], exp_data);
      end
    end
  endtask

  // R5 R10: passing packet blocks same-ring injection only
  task automatic t_backpressure();
    @(negedge clk);
    drive(0, 1'b1, 3'd2, 4'h1, pat(4'h1));
    #1 chk("R5 ready stop0", DW'(inj_ready[0]), DW'(1));
    @(negedge clk);
    drive(0, 1'b0, '0, '0, '0);
    drive(1, 1'b1, 3'd3, 4'h2, pat(4'h2));
    #1 chk("R5 ready low under passing packet", DW'(inj_ready[1]), DW'(0));
    drive(1, 1'b1, 3'd0, 4'h3, pat(4'h3));
    #1 chk("R10 opposite ring not blocked", DW'(inj_ready[1]), DW'(1));
    @(negedge clk);
    chk("R5 passing packet arrives", DW'({cw_v[2], cw_t[2*TW +: TW]}), DW'({1'b1, 4'h1}));
    chk("R10 ccw packet arrives", DW'({ccw_v[0], ccw_t[0 +: TW]}), DW'({1'b1, 4'h3}));
    drive(1, 1'b1, 3'd3, 4'h2, pat(4'h2));
    #1 chk("R5 ready after slot clears", DW'(inj_ready[1]), DW'(1));
    @(negedge clk);
    drive(1, 1'b0, '0, '0, '0);
    chk("R5 held packet not early", DW'(cw_v[3]), DW'(0));
    @(negedge clk);
    chk("R5 held packet arrives", DW'({cw_v[3], cw_t[3*TW +: TW]}), DW'({1'b1, 4'h2}));
    @(negedge clk);
    chk("R7 ring idle after", DW'({cw_v, ccw_v}), '0);
  endtask

  // R6
  task automatic t_slot_reuse();
    @(negedge clk);
    drive(0, 1'b1, 3'd1, 4'h4, pat(4'h4));
    @(negedge clk);
    drive(0, 1'b0, '0, '0, '0);
    drive(1, 1'b1, 3'd2, 4'h5, pat(4'h5));
    #1 chk("R6 ready on ejecting slot", DW'(inj_ready[1]), DW'(1));
    chk("R6 ejection at stop1", DW'({cw_v[1], cw_t[1*TW +: TW]}), DW'({1'b1, 4'h4}));
    @(negedge clk);
    drive(1, 1'b0, '0, '0, '0);
    chk("R6 reused slot delivers", DW'({cw_v[2], cw_t[2*TW +: TW]}), DW'({1'b1, 4'h5}));
  endtask

  // R8
  task automatic t_discard(input int s, input logic [IW-1:0] d);
    @(negedge clk);
    drive(s, 1'b1, d, 4'h9, pat(4'h9));
    #1 chk("R8 ready on discarded dest", DW'(inj_ready[s]), DW'(1));
    @(negedge clk);
    drive(s, 1'b0, '0, '0, '0);
    for (int k = 0; k < N; k++) begin
      if (k > 0) @(negedge clk);
      chk("R8 nothing ejected", DW'({cw_v, ccw_v}), '0);
    end
  endtask

  // R4 on four stops: distance 2 is a tie
  task automatic t_tie(input int src, input int dst, input logic [3:0] tag);
    @(negedge clk);
    r4_valid[src] = 1'b1;
    r4_dest[src*2 +: 2] = 2'(dst);
    r4_tag[src*4 +: 4] = tag;
    r4_data[src*32 +: 32] = {28'h0, tag};
    @(negedge clk);
    r4_valid[src] = 1'b0;
    chk("R4 tie not early", DW'({r4_cw_v, r4_ccw_v}), '0);
    @(negedge clk);
    chk("R4 tie uses clockwise", DW'({r4_cw_v[dst], r4_ccw_v[dst]}), DW'(2'b10));
    chk("R4 tie tag", DW'(r4_cw_t[dst*4 +: 4]), DW'(tag));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int s = 0; s < N; s++)
      for (int t = 0; t < N; t++)
        if (s != t) t_route(s, t);
    t_backpressure();
    t_slot_reuse();
    t_discard(2, 3'd2);
    t_discard(3, 3'd7);
    t_tie(0, 2, 4'h7);
    t_tie(3, 1, 4'hB);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule